// File: doc/BRIEF.md
# Page-Mode Nonvolatile Memory Write Controller

This block is a synchronous behavioural model of the write side of a byte-wide nonvolatile memory that is programmed one page at a time. A host loads bytes into a page latch by pulling chip enable and write enable low while output enable is high. It can load any number of bytes, from one up to the full page. When no further byte arrives within a load window, the block commits the whole latched page to its internal storage array. The commit takes a fixed number of clock cycles, counted by a self-timed program counter.

Before the first byte of a sequence is latched, the page latch is filled with the current array contents of that page. Any byte the host does not load is therefore rewritten with its old value. While programming is in progress, a read at any address returns the inverted value of the last byte loaded. The host can poll the last address it wrote until the true data comes back. The active-low reset clears any pending load and keeps programming from running.

Top module: `pagemem_wrctl`

## Requirements
- R1: While `rst_n` is low, `busy` is low and no programming takes place. A load sequence in progress when reset is asserted is discarded: after release the array keeps its previous contents and no programming starts.
- R2: A byte is loaded only on the first cycle in which `ce_n`=0, `oe_n`=1 and `we_n`=0 all hold. With `oe_n`=0 or `we_n`=1 nothing is loaded and no programming begins.
- R3: Address bits [PAGE_BITS-1:0] select the byte within a page, and the bits above select the page. The page is fixed by the first byte of a sequence. Later bytes of that sequence land in the same page at their low-bit offset, whatever their upper bits.
- R4: Bytes of the page not loaded in a sequence keep their previous array values after programming.
- R5: Programming starts LOAD_WIN cycles after the last accepted load: `busy` is low after LOAD_WIN-1 edges and high after LOAD_WIN edges. Each new load restarts this window.
- R6: `busy` stays high for exactly PROG_CYC clock cycles, and the array is updated when it falls.
- R7: While `busy` is high, `dout` equals the bitwise complement of the last byte loaded, whatever the address.
- R8: When `busy` is low, `dout` returns the array byte at `addr`. After programming completes, the last address written reads back its true data.
- R9: Load requests made while `busy` is high are ignored. They change no array byte and start no later programming.
- R10: `dout_en` is 1 exactly when `ce_n` and `oe_n` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Programming clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in upper bits, offset in low PAGE_BITS |
| din | input | 8 | Byte to load |
| dout | output | 8 | Read data, or the inverted last byte while busy |
| dout_en | output | 1 | High when the read data is driven |
| busy | output | 1 | High while the page is being programmed |

## Verification
On every cycle the assertions check four things. A load strobe appears only under the write condition. Programming begins only on the cycle after the load window expires, and each programming interval lasts exactly PROG_CYC cycles. While busy, the polled output holds steady as the address changes. Reset forces the block idle. Only the directed scenarios can show where each byte lands in the array. They also cover the preservation of bytes that were not loaded, the folding of a stray page address into the latched page, the restart of the window, and requests that are dropped during programming. The same holds for an aborted sequence under reset.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pw_wrstrobe.sv
module pw_wrstrobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic load_ev
);
    logic cond;
    logic cond_d, cond_q;

    assign cond = !ce_n && oe_n && !we_n;

    always_comb begin
        cond_d = cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond_d;
    end

    // one pulse on entry into the write condition
    assign load_ev = cond && !cond_q;
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = len;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == W'(1)) && !start;
endmodule

// File: rtl/pw_array.sv
module pw_array #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 6
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [ADDR_W-PAGE_BITS-1:0]   wr_page,
    input  logic [(1<<PAGE_BITS)*8-1:0]   wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_byte,
    input  logic [ADDR_W-PAGE_BITS-1:0]   pg_sel,
    output logic [(1<<PAGE_BITS)*8-1:0]   pg_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PBYTES = 1 << PAGE_BITS;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < PBYTES; b++) begin
                mem[{wr_page, PAGE_BITS'(b)}] <= wr_data[b*8 +: 8];
            end
        end
    end

    assign rd_byte = mem[rd_addr];

    for (genvar g = 0; g < PBYTES; g++) begin : g_pgrd
        assign pg_data[g*8 +: 8] = mem[{pg_sel, PAGE_BITS'(g)}];
    end
endmodule

// File: rtl/pagemem_wrctl.sv
module pagemem_wrctl
    import pw_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 6,
    parameter int LOAD_WIN  = 600,
    parameter int PROG_CYC  = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int PG_W   = ADDR_W - PAGE_BITS;
    localparam int PBYTES = 1 << PAGE_BITS;
    localparam int LAT_W  = PBYTES * 8;
    localparam int WIN_W  = $clog2(LOAD_WIN + 1);
    localparam int PRG_W  = $clog2(PROG_CYC + 1);

    typedef struct packed {
        pw_state_e          st;
        logic [PG_W-1:0]    page;
        logic [7:0]         last;
        logic [LAT_W-1:0]   lat;
    } ctl_t;

    ctl_t d, q;

    logic                 load_ev;
    logic                 win_go, win_exp;
    logic                 prog_go, prog_exp;
    logic                 arr_we;
    logic [7:0]           rd_byte;
    logic [LAT_W-1:0]     pg_rd;
    logic [PAGE_BITS-1:0] off;

    assign off = addr[PAGE_BITS-1:0];

    pw_wrstrobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .load_ev(load_ev)
    );

    pw_timer #(.W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .start(win_go),
        .len(WIN_W'(LOAD_WIN)), .expire(win_exp)
    );

    pw_timer #(.W(PRG_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .start(prog_go),
        .len(PRG_W'(PROG_CYC)), .expire(prog_exp)
    );

    pw_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_arr (
        .clk(clk), .wr_en(arr_we), .wr_page(q.page), .wr_data(q.lat),
        .rd_addr(addr), .rd_byte(rd_byte),
        .pg_sel(addr[ADDR_W-1:PAGE_BITS]), .pg_data(pg_rd)
    );

    always_comb begin
        d       = q;
        win_go  = 1'b0;
        prog_go = 1'b0;
        arr_we  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (load_ev) begin
                    // seed the latch with the page's current contents
                    d.lat             = pg_rd;
                    d.lat[off*8 +: 8] = din;
                    d.page            = addr[ADDR_W-1:PAGE_BITS];
                    d.last            = din;
                    d.st              = ST_LOAD;
                    win_go            = 1'b1;
                end
            end
            ST_LOAD: begin
                if (load_ev) begin
                    d.lat[off*8 +: 8] = din;
                    d.last            = din;
                    win_go            = 1'b1;
                end else if (win_exp) begin
                    d.st    = ST_PROG;
                    prog_go = 1'b1;
                end
            end
            ST_PROG: begin
                if (prog_exp) begin
                    arr_we = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.page <= '0;
            q.last <= '0;
            q.lat  <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st == ST_PROG);
    assign dout    = busy ? ~q.last : rd_byte;
    assign dout_en = !ce_n && !oe_n;
endmodule

// File: rtl/pw_wrctl_chk.sv
module pw_wrctl_chk #(
    parameter int PROG_CYC = 20000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       load_ev,
    input logic       win_exp,
    input logic       busy,
    input logic       dout_en,
    input logic [7:0] dout
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !busy);

    // R2
    load_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ev |-> (!ce_n && oe_n && !we_n));

    // R5
    start_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(win_exp));

    // R6
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == PROG_CYC));

    // R7
    poll_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dout_en && $past(dout_en)) |-> (dout == $past(dout)));
endmodule

bind pagemem_wrctl pw_wrctl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .load_ev(load_ev), .win_exp(win_exp), .busy(busy),
    .dout_en(dout_en), .dout(dout)
);

// File: tb/pagemem_wrctl_tb.sv
module pagemem_wrctl_tb;
    localparam int AW = 11;
    localparam int PB = 6;
    localparam int NB = 1 << PB;
    localparam int W  = 16;
    localparam int P  = 100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en;
    logic          busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [7:0] ref_mem [1 << AW];

    always #2.5 clk = ~clk;

    pagemem_wrctl #(.ADDR_W(AW), .PAGE_BITS(PB), .LOAD_WIN(W), .PROG_CYC(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got cycle %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int page, input int off);
        return AW'(page * NB + off);
    endfunction

    task automatic load_byte(input logic [AW-1:0] a, input logic [7:0] v);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = v;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        check(req, dout, exp);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // called right after the last load; checks window, polling and duration
    task automatic run_program(input logic [AW-1:0] poll_a, input logic [7:0] last);
        int n;
        repeat (W - 1) @(negedge clk);
        check("R5 busy before window end", busy, 0);
        @(negedge clk);
        check("R5 busy at window end", busy, 1);
        n = 1;
        read_chk("R7 polled data", poll_a, ~last);
        if (busy) n++;
        while (busy) begin
            @(negedge clk);
            if (busy) n++;
        end
        check("R6 busy cycles", n, P);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R10 dout_en idle", dout_en, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_full_page(input int page, input int seed);
        for (int i = 0; i < NB; i++) begin
            load_byte(mk(page, i), 8'(seed + i * 3));
            ref_mem[page * NB + i] = 8'(seed + i * 3);
        end
        run_program(mk(page ^ 1, 17), 8'(seed + (NB - 1) * 3));
        for (int i = 0; i < NB; i++)
            read_chk("R8 R3 full page readback", mk(page, i), ref_mem[page * NB + i]);
    endtask

    task automatic t_partial;
        load_byte(mk(0, 5), 8'hA5);
        load_byte(mk(0, 9), 8'h3C);
        load_byte(mk(1, 20), 8'h77);   // folded into page 0
        ref_mem[5] = 8'hA5; ref_mem[9] = 8'h3C; ref_mem[20] = 8'h77;
        run_program(mk(1, 3), 8'h77);
        read_chk("R8 last address true data", mk(0, 20), 8'h77);
        read_chk("R3 loaded byte 5", mk(0, 5), 8'hA5);
        read_chk("R3 loaded byte 9", mk(0, 9), 8'h3C);
        read_chk("R4 unloaded byte kept", mk(0, 6), ref_mem[6]);
        read_chk("R4 unloaded byte 63 kept", mk(0, 63), ref_mem[63]);
        read_chk("R3 other page untouched", mk(1, 20), ref_mem[NB + 20]);
    endtask

    task automatic t_restart;
        load_byte(mk(1, 2), 8'h21);
        repeat (W - 4) @(negedge clk);
        check("R5 no start inside window", busy, 0);
        load_byte(mk(1, 3), 8'h22);
        ref_mem[NB + 2] = 8'h21; ref_mem[NB + 3] = 8'h22;
        run_program(mk(0, 0), 8'h22);
        read_chk("R5 restarted byte a", mk(1, 2), 8'h21);
        read_chk("R5 restarted byte b", mk(1, 3), 8'h22);
    endtask

    task automatic t_busy_ignore;
        int seen;
        load_byte(mk(0, 30), 8'h99);
        ref_mem[30] = 8'h99;
        repeat (W) @(negedge clk);
        check("R9 busy before stray load", busy, 1);
        load_byte(mk(0, 30), 8'h01);
        load_byte(mk(1, 31), 8'h02);
        while (busy) @(negedge clk);
        seen = 0;
        for (int i = 0; i < W + 6; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check("R9 no later programming", seen, 0);
        read_chk("R9 byte not overwritten", mk(0, 30), 8'h99);
        read_chk("R9 other byte not written", mk(1, 31), ref_mem[NB + 31]);
    endtask

    task automatic t_inhibit;
        int seen;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = mk(0, 40); din = 8'hEE;
        repeat (2) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        seen = 0;
        for (int i = 0; i < W + 6; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check("R2 inhibited write starts nothing", seen, 0);
        read_chk("R2 inhibited byte unchanged", mk(0, 40), ref_mem[40]);
    endtask

    task automatic t_reset_abort;
        int seen;
        load_byte(mk(1, 7), 8'hC3);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 busy low in reset", busy, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < W + 6; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check("R1 aborted load never programs", seen, 0);
        read_chk("R1 aborted byte unchanged", mk(1, 7), ref_mem[NB + 7]);
    endtask

    task automatic t_oe;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R10 oe high", dout_en, 0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        check("R10 ce high", dout_en, 0);
        ce_n = 1'b0; oe_n = 1'b0; #1;
        check("R10 both low", dout_en, 1);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_full_page(0, 8'h11);
        t_full_page(1, 8'h5A);
        t_partial();
        t_restart();
        t_busy_ignore();
        t_inhibit();
        t_reset_abort();
        t_oe();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule